// File: doc/BRIEF.md
# Synchronous Serial Master/Slave Port

This block is a byte-wide synchronous serial port. It can run as a master, where it makes the shift clock from the system clock through a prescaler and an 8-bit divider. It can also run as a slave, where it takes the shift clock from an external pin through a synchroniser. The host writes bytes into a one-deep transmit holding register. That register feeds a transmit shift register, so the host can load the next byte while the current one is on the wire. The receive shift register runs in parallel with transmission. It delivers each completed byte into a receive holding register that the host reads.

A frame always moves exactly 8 bits, most significant bit first. The host picks one of four clock modes with two bits. One bit chooses which clock edge launches data and which samples it. The other chooses whether the first edge of a frame is a launch edge or a sample edge, and that in turn fixes the idle level of the clock. Slave selection is done outside the block. The transmit interrupt can fire either when a byte leaves the holding register or when the last bit has left the shift register. A receive overrun is reported early, as soon as the second-to-last bit of a frame arrives while the previous byte is still unread.

Top module: `ssp_port`

## Requirements
- R1: After reset tx_empty=1, rx_full=0, overrun=0, irq_tx=0 and irq_rx=0. With edge_sel=0 and phase_sel=0, sclk_out=1.
- R2: wr_tx loads wr_data into the holding register and clears tx_empty. A frame starts only while tx_en=1 and tx_empty=0. Starting a frame moves the byte into the shift register and sets tx_empty=1. While tx_en=0 no clock transition occurs.
- R3: In master mode (master=1) a frame is exactly 16 sclk_out transitions. Consecutive transitions are (div_n+1)*F system clocks apart, where F is 1, 2, 8 or 32 for presc_sel = 0, 1, 2 or 3.
- R4: The idle level of sclk_out between frames is NOT(edge_sel XOR phase_sel). With phase_sel=0 the first edge of a frame is a launch edge. With phase_sel=1 it is a sample edge.
- R5: With edge_sel=0, data is launched on the falling clock edge and sdi is sampled on the rising edge. With edge_sel=1 these edges swap. sdo carries the byte most significant bit first and holds steady at every sample edge.
- R6: If rx_en=1 when a frame starts, the received byte goes to rx_data at the end of the frame. rx_full is then set and irq_rx pulses for one cycle. rd_rx clears rx_full.
- R7: irq_tx is a single-cycle pulse, once per frame. With txirq_sel=0 it fires before the first clock transition of the frame. With txirq_sel=1 it fires after the last transition.
- R8: If rx_full is still set when the 7th bit of a receiving frame is sampled, overrun is set. For that frame irq_rx does not pulse and rx_data keeps its old byte. overrun stays set until ovr_clr.
- R9: In slave mode (master=0) bits shift on the edges of sclk_in after a two-flop synchroniser. sclk_oe=0, and sclk_out holds still while the mode inputs are stable. The system clock must be at least four times faster than sclk_in.
- R10: A frame started with rx_en=0 still transmits. It leaves rx_full and rx_data unchanged and does not pulse irq_rx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_tx | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_rx | input | 1 | Read strobe, clears rx_full |
| rx_data | output | 8 | Receive holding register |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable, latched at frame start |
| master | input | 1 | 1 = generate the clock, 0 = take it from sclk_in |
| edge_sel | input | 1 | 0 = launch on falling and sample on rising, 1 = the reverse |
| phase_sel | input | 1 | 0 = first edge launches, 1 = first edge samples |
| txirq_sel | input | 1 | 0 = irq_tx when the holding register empties, 1 = irq_tx when the shift register finishes |
| presc_sel | input | 2 | Prescaler select: divide by 1, 2, 8 or 32 |
| div_n | input | 8 | Divider value n, half period = (n+1) prescaled ticks |
| ovr_clr | input | 1 | Clears overrun |
| sclk_in | input | 1 | External shift clock (slave) |
| sclk_out | output | 1 | Generated shift clock (master) |
| sclk_oe | output | 1 | Output enable for sclk_out |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| overrun | output | 1 | Sticky overrun flag |
| irq_tx | output | 1 | Transmit interrupt pulse |
| irq_rx | output | 1 | Receive interrupt pulse |

## Verification
The hardest case to reach is the narrow overrun window. It opens at the 7th sampled bit of a receiving frame, not at the frame end, and only while a previous byte still sits unread. The stimulus first clears the flag and runs one receiving frame without reading it back. It then starts a second frame and records the overrun output at the 7th and 8th sample edges, which must read clear and then set. Slave timing is reached by driving sclk_in from the bench with a half period of several system clocks. The bench launches sdi bits at the edges that the chosen mode calls for, in all four modes picked at random.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    // prescaler counter width: the largest prescale ratio is 2**PRE_W
    localparam int PRE_W = 5;

    typedef enum logic {
        TXIRQ_ON_LOAD = 1'b0,
        TXIRQ_ON_DONE = 1'b1
    } txirq_e;

    // idle level of the shift clock for a given edge/phase choice
    function automatic logic idle_level(input logic edge_sel, input logic phase_sel);
        return ~(edge_sel ^ phase_sel);
    endfunction

    // clock level reached by a sample edge
    function automatic logic sample_level(input logic edge_sel);
        return ~edge_sel;
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             master,
    input  logic             idle_lvl,
    input  logic [1:0]       presc_sel,
    input  logic [DIV_W-1:0] div_n,
    input  logic             sclk_in,
    output logic             ev,
    output logic             ev_lvl,
    output logic             sclk_out
);

    localparam int SYNC_W = 3;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DIV_W-1:0]  div;
        logic              mclk;
        logic [SYNC_W-1:0] sync;   // [0],[1] synchroniser, [2] previous level
    } cg_t;

    cg_t  q, d;
    logic tick;

    always_comb begin
        case (presc_sel)
            2'd0:    tick = 1'b1;
            2'd1:    tick = q.pre[0];
            2'd2:    tick = &q.pre[2:0];
            default: tick = &q.pre[PRE_W-1:0];
        endcase
    end

    always_comb begin
        d        = q;
        d.pre    = q.pre + 1'b1;
        d.sync   = {q.sync[SYNC_W-2:0], sclk_in};
        ev       = 1'b0;
        ev_lvl   = q.mclk;
        if (master) begin
            if (!run) begin
                d.mclk = idle_lvl;
                d.div  = '0;
            end else if (tick) begin
                if (q.div == div_n) begin
                    d.div  = '0;
                    d.mclk = ~q.mclk;
                    ev     = 1'b1;
                    ev_lvl = ~q.mclk;
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
        end else begin
            d.mclk = idle_lvl;
            d.div  = '0;
            ev     = run && (q.sync[2] != q.sync[1]);
            ev_lvl = q.sync[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pre  <= '0;
            q.div  <= '0;
            q.mclk <= 1'b1;
            q.sync <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk_out = q.mclk;

endmodule

// File: rtl/ssp_engine.sv
module ssp_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              ev,
    input  logic              ev_lvl,
    input  logic              samp_lvl,
    input  logic              master,
    input  logic              sdi,
    output logic              busy,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_byte,
    output logic              seventh,
    output logic              rx_done,
    output logic              done
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int TOG_W = $clog2(2 * DATA_W + 1);
    localparam logic [CNT_W-1:0] PEN_CNT  = CNT_W'(DATA_W - 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);
    localparam logic [TOG_W-1:0] LAST_TOG = TOG_W'(2 * DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic [DATA_W-1:0] tsh;
        logic [DATA_W-1:0] rsh;
        logic [CNT_W-1:0]  nsamp;
        logic [TOG_W-1:0]  ntog;
        logic              seventh;
        logic              rxd;
        logic              done;
    } en_t;

    en_t q, d;

    always_comb begin
        d         = q;
        d.seventh = 1'b0;
        d.rxd     = 1'b0;
        d.done    = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.tsh   = tx_byte;
                d.nsamp = '0;
                d.ntog  = '0;
            end
        end else if (ev) begin
            d.ntog = q.ntog + 1'b1;
            if (ev_lvl == samp_lvl) begin
                d.rsh   = {q.rsh[DATA_W-2:0], sdi};
                d.nsamp = q.nsamp + 1'b1;
                if (q.nsamp == PEN_CNT) d.seventh = 1'b1;
                if (q.nsamp == LAST_CNT) begin
                    d.rxd = 1'b1;
                    if (!master) begin
                        d.done = 1'b1;
                        d.busy = 1'b0;
                    end
                end
            end else if (q.nsamp != '0) begin
                d.tsh = {q.tsh[DATA_W-2:0], 1'b0};
            end
            if (master && q.ntog == LAST_TOG) begin
                d.done = 1'b1;
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign sdo     = q.tsh[DATA_W-1];
    assign rx_byte = q.rsh;
    assign seventh = q.seventh;
    assign rx_done = q.rxd;
    assign done    = q.done;

endmodule

// File: rtl/ssp_port.sv
module ssp_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_tx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_rx,
    output logic [DATA_W-1:0] rx_data,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              master,
    input  logic              edge_sel,
    input  logic              phase_sel,
    input  logic              txirq_sel,
    input  logic [1:0]        presc_sel,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              ovr_clr,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdo,
    input  logic              sdi,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic              irq_tx,
    output logic              irq_rx
);

    typedef struct packed {
        logic [DATA_W-1:0] txbuf;
        logic              txfull;
        logic [DATA_W-1:0] rxbuf;
        logic              rxfull;
        logic              ovr;
        logic              frx;    // current frame receives
        logic              fovr;   // current frame overran
        logic              itx;
        logic              irx;
    } hs_t;

    hs_t  q, d;
    logic busy, ev, ev_lvl, seventh, rxd, done, start;
    logic [DATA_W-1:0] rx_byte;
    txirq_e irq_mode;

    assign irq_mode = txirq_e'(txirq_sel);
    assign start    = tx_en && q.txfull && !busy;

    ssp_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .master   (master),
        .idle_lvl (idle_level(edge_sel, phase_sel)),
        .presc_sel(presc_sel),
        .div_n    (div_n),
        .sclk_in  (sclk_in),
        .ev       (ev),
        .ev_lvl   (ev_lvl),
        .sclk_out (sclk_out)
    );

    ssp_engine #(.DATA_W(DATA_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (q.txbuf),
        .ev      (ev),
        .ev_lvl  (ev_lvl),
        .samp_lvl(sample_level(edge_sel)),
        .master  (master),
        .sdi     (sdi),
        .busy    (busy),
        .sdo     (sdo),
        .rx_byte (rx_byte),
        .seventh (seventh),
        .rx_done (rxd),
        .done    (done)
    );

    always_comb begin
        d     = q;
        d.itx = 1'b0;
        d.irx = 1'b0;
        if (start) begin
            d.txfull = 1'b0;
            d.frx    = rx_en;
            d.fovr   = 1'b0;
            if (irq_mode == TXIRQ_ON_LOAD) d.itx = 1'b1;
        end
        if (done && irq_mode == TXIRQ_ON_DONE) d.itx = 1'b1;
        if (wr_tx) begin
            d.txbuf  = wr_data;
            d.txfull = 1'b1;
        end
        if (rd_rx)   d.rxfull = 1'b0;
        if (ovr_clr) d.ovr    = 1'b0;
        if (seventh && q.frx && q.rxfull && !rd_rx) begin
            d.ovr  = 1'b1;
            d.fovr = 1'b1;
        end
        if (rxd && q.frx && !q.fovr) begin
            d.rxbuf  = rx_byte;
            d.rxfull = 1'b1;
            d.irx    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data  = q.rxbuf;
    assign tx_empty = ~q.txfull;
    assign rx_full  = q.rxfull;
    assign overrun  = q.ovr;
    assign irq_tx   = q.itx;
    assign irq_rx   = q.irx;
    assign sclk_oe  = master;

endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_tx,
    input logic tx_empty,
    input logic rx_full,
    input logic irq_tx,
    input logic irq_rx,
    input logic overrun,
    input logic ovr_clr,
    input logic master,
    input logic edge_sel,
    input logic phase_sel,
    input logic sclk_out,
    input logic busy
);

    AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !$rose(busy)); // R2

    AST_TXBUF_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty && !wr_tx |=> tx_empty); // R2

    AST_TX_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |=> !irq_tx); // R7

    AST_RXFULL_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> irq_rx); // R6

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun); // R8

    AST_SLAVE_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master && $stable(master) && $stable(edge_sel) && $stable(phase_sel)
        |=> $stable(sclk_out)); // R9

endmodule

bind ssp_port ssp_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .wr_tx    (wr_tx),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .irq_tx   (irq_tx),
    .irq_rx   (irq_rx),
    .overrun  (overrun),
    .ovr_clr  (ovr_clr),
    .master   (master),
    .edge_sel (edge_sel),
    .phase_sel(phase_sel),
    .sclk_out (sclk_out),
    .busy     (busy)
);

// File: tb/sim_ssp_port.sv
module sim_ssp_port;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, wr_tx, rd_rx, tx_en, rx_en, master, edge_sel, phase_sel;
    logic       txirq_sel, ovr_clr, sclk_in, bsdi, loopback;
    logic [7:0] wr_data, div_n, rx_data;
    logic [1:0] presc_sel;
    logic       sclk_out, sclk_oe, sdo, sdi, tx_empty, rx_full, overrun, irq_tx, irq_rx;

    assign sdi = loopback ? sdo : bsdi;

    ssp_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx),
        .rx_data(rx_data), .tx_en(tx_en), .rx_en(rx_en), .master(master),
        .edge_sel(edge_sel), .phase_sel(phase_sel), .txirq_sel(txirq_sel),
        .presc_sel(presc_sel), .div_n(div_n), .ovr_clr(ovr_clr), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo(sdo), .sdi(sdi),
        .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    int n_chk = 0, n_err = 0, cyc = 0, c_itx = 0, c_irx = 0, last_itx = 0;
    bit fin = 0;

    task automatic tick();
        @(negedge clk);
        cyc++;
        if (irq_tx) begin c_itx++; last_itx = cyc; end
        if (irq_rx) c_irx++;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fj(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 8 : 32;
    endfunction

    function automatic logic idle_of(input logic ed, input logic ph);
        return ~(ed ^ ph);
    endfunction

    task automatic host_write(input logic [7:0] b);
        wr_tx = 1'b1; wr_data = b;
        tick();
        wr_tx = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] v);
        v = rx_data; rd_rx = 1'b1;
        tick();
        rd_rx = 1'b0;
    endtask

    task automatic master_frame(input logic [7:0] txb, input int exp_rx, input bit exp_ovr);
        int e, k, prev, bad, first_e, last_e, itx0, irx0, h, guard;
        logic [7:0] got;
        logic pl, o7, o8;
        e = 0; k = 0; prev = 0; bad = 0; first_e = 0; last_e = 0; guard = 0;
        got = '0; o7 = 1'b0; o8 = 1'b0;
        loopback = 1'b1;
        h = (int'(div_n) + 1) * fj(presc_sel);
        check("R4 idle level before frame", sclk_out, idle_of(edge_sel, phase_sel));
        itx0 = c_itx; irx0 = c_irx;
        host_write(txb);
        tx_en = 1'b1;
        pl = sclk_out;
        while (e < 16 && guard < 20000) begin
            tick(); guard++;
            if (sclk_out !== pl) begin
                e++;
                if (e == 1) first_e = cyc;
                else if (cyc - prev != h) bad++;
                prev = cyc; last_e = cyc;
                if (sclk_out == ~edge_sel) begin
                    got = {got[6:0], sdo}; k++;
                    if (k == 7) o7 = overrun;
                    if (k == 8) o8 = overrun;
                end
                pl = sclk_out;
            end
        end
        repeat (4) tick();
        tx_en = 1'b0;
        check("R3 transitions per frame", e, 16);
        check("R3 half period", bad, 0);
        check("R5 msb-first bits on sdo", got, txb);
        check("R4 idle level after frame", sclk_out, idle_of(edge_sel, phase_sel));
        check("R2 holding register empty after start", tx_empty, 1);
        check("R7 one irq_tx per frame", c_itx - itx0, 1);
        if (txirq_sel) check("R7 irq_tx after last edge", int'(last_itx > last_e), 1);
        else           check("R7 irq_tx before first edge", int'(last_itx < first_e), 1);
        check("R6 irq_rx count", c_irx - irx0, exp_rx);
        if (exp_ovr) begin
            check("R8 overrun clear before 7th bit", o7, 0);
            check("R8 overrun set by 8th bit", o8, 1);
        end
    endtask

    task automatic slave_frame(input logic [7:0] txb, input logic [7:0] rxb, input int half);
        int k, irx0;
        logic [7:0] got, v;
        logic nl;
        k = 0; got = '0;
        loopback = 1'b0;
        sclk_in = idle_of(edge_sel, phase_sel);
        bsdi = rxb[7];
        repeat (4) tick();
        irx0 = c_irx;
        host_write(txb);
        tx_en = 1'b1;
        repeat (4) tick();
        for (int e = 0; e < 16; e++) begin
            repeat (half) tick();
            nl = ~sclk_in;
            if (nl == ~edge_sel) begin
                got = {got[6:0], sdo}; k++;
            end else if (k > 0 && k < 8) begin
                bsdi = rxb[7-k];
            end
            sclk_in = nl;
        end
        repeat (8) tick();
        tx_en = 1'b0;
        check("R9 slave sdo bits", got, txb);
        check("R9 slave irq_rx", c_irx - irx0, 1);
        check("R9 slave sclk_oe low", sclk_oe, 0);
        host_read(v);
        check("R9 slave received byte", v, rxb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, b, keep;
        int tog;
        logic pl;
        void'($urandom(32'd2024));
        rst_n = 0; wr_tx = 0; rd_rx = 0; tx_en = 0; rx_en = 1; master = 1;
        edge_sel = 0; phase_sel = 0; txirq_sel = 0; ovr_clr = 0; sclk_in = 1;
        bsdi = 0; loopback = 1; wr_data = 0; div_n = 8'd1; presc_sel = 2'd0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 tx_empty", tx_empty, 1);
        check("R1 rx_full", rx_full, 0);
        check("R1 overrun", overrun, 0);
        check("R1 irq_tx", irq_tx, 0);
        check("R1 irq_rx", irq_rx, 0);
        check("R1 sclk_out idle", sclk_out, 1);

        // R2: data loaded but transmit disabled
        host_write(8'hA5);
        check("R2 write clears tx_empty", tx_empty, 0);
        tog = 0; pl = sclk_out;
        repeat (100) begin tick(); if (sclk_out !== pl) tog++; pl = sclk_out; end
        check("R2 no clock while tx_en=0", tog, 0);
        check("R2 byte still held", tx_empty, 0);

        // random master frames
        for (int i = 0; i < 12; i++) begin
            edge_sel = 1'($urandom()); phase_sel = 1'($urandom());
            txirq_sel = 1'($urandom()); presc_sel = 2'($urandom());
            div_n = 8'($urandom_range(0, 4));
            b = 8'($urandom());
            if (i == 0) b = 8'h80;
            if (i == 1) b = 8'h01;
            repeat (3) tick();
            master_frame(b, 1, 0);
            check("R6 rx_full after frame", rx_full, 1);
            host_read(v);
            check("R6 loopback byte", v, b);
            check("R6 read clears rx_full", rx_full, 0);
        end

        // R10: receive disabled
        keep = rx_data;
        rx_en = 0;
        master_frame(8'h3C, 0, 0);
        check("R10 rx_full unchanged", rx_full, 0);
        check("R10 rx_data unchanged", rx_data, keep);
        rx_en = 1;

        // R8: overrun on the second unread frame
        edge_sel = 0; phase_sel = 1; presc_sel = 2'd1; div_n = 8'd2; txirq_sel = 1;
        ovr_clr = 1; tick(); ovr_clr = 0;
        repeat (3) tick();
        master_frame(8'h81, 1, 0);
        check("R8 first byte pending", rx_full, 1);
        master_frame(8'h7E, 0, 1);
        check("R8 buffer not replaced", rx_data, 8'h81);
        repeat (20) tick();
        check("R8 overrun sticky", overrun, 1);
        host_read(v);
        ovr_clr = 1; tick(); ovr_clr = 0;
        check("R8 ovr_clr clears", overrun, 0);

        // slave frames in random modes
        master = 0;
        for (int i = 0; i < 8; i++) begin
            edge_sel = 1'($urandom()); phase_sel = 1'($urandom());
            if (i < 4) begin edge_sel = i[0]; phase_sel = i[1]; end
            slave_frame(8'($urandom()), 8'($urandom()), 6 + int'($urandom_range(0, 4)));
        end

        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule